// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes a left and a right audio sample, offered once per sample period, and sends them out over a three-wire serial audio link made of a data line, a bit clock and a word select. As master, it derives the bit clock and word select from a system clock that runs at 256 times the sample rate. The bit clock runs at a quarter of the system clock, and each channel slot lasts 32 bit clocks. As slave, it follows a bit clock and word select driven from outside, and accepts bursts of any length followed by idle gaps.

A format input picks between two MSB placements. With the select high, the data is left-justified and the MSB comes in the first bit period of a slot. With the select low, the data uses the delayed framing of the common inter-IC sound bus, and the MSB comes one bit later. A second input chooses an extended set of framings, but only in slave mode, and there it also swaps the word-select polarity. When the run input goes low, the block stops driving all three link lines by dropping their output enables. After the run input returns high, the data line is held low for a number of stereo frames while the upstream filter settles. That number depends on whether the high-pass filter is enabled.

Top module: `audio_ser_port`

## Requirements
- R1: While `runEn` is low, `sdoOe`, `sckOe` and `wsOe` are low from the next clock on, and `sdoOut` is low; the same holds directly after reset.
- R2: In master mode, `sckOut` has a period of `CLK_DIV` clocks, and `wsOut` changes only together with a falling edge of `sckOut`. Each slot lasts `SLOT_BITS` bit clocks. `wsOut` low marks the left slot and high marks the right slot, whatever the value of `extSel`.
- R3: `sdoOut` changes only while the bit clock is low, so it is settled at every rising edge. Data is sent MSB first.
- R4: With `fmtSel` = 1, the MSB of the slot's sample goes out in the first bit period after the word-select change. The remaining `DATA_W`-1 bits follow, and every later bit of the slot is 0.
- R5: With `fmtSel` = 0, the first bit period after the word-select change carries 0. The MSB goes out in the second bit period and the LSB in bit period `DATA_W`+1. Every later bit of the slot is 0.
- R6: With `slaveSel` = 1, `sckOe` and `wsOe` stay low. Each falling edge of `sckIn` advances the output by one bit, and `sdoOut` is valid at most 3 clocks after that edge. Bursts of any length may be separated by idle gaps with `sckIn` held high.
- R7: In slave mode with `extSel` = 1, `wsIn` high marks the left slot. In every other case `wsIn` low marks the left slot.
- R8: A stereo frame begins when word select changes into the left slot. At that point both staged samples are captured. A new sample strobed during the frame does not change that frame's right slot.
- R9: After `runEn` rises, the first `HOLD_PLAIN` stereo frames are sent as all zeros when `hpfOn` = 0, or the first `HOLD_HPF` frames when `hpfOn` = 1. Only frames whose left-slot start is seen after the rise are counted. The next frame carries data.
- R10: The hold count of R9 restarts from zero at every exit from standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | High for operation, low for standby |
| slaveSel | input | 1 | 1 selects slave mode, 0 selects master mode |
| fmtSel | input | 1 | 1 selects left-justified data, 0 selects one-bit-delayed data |
| extSel | input | 1 | In slave mode, selects the extended framings and the swapped word-select polarity |
| hpfOn | input | 1 | High-pass filter enabled upstream; selects the longer wake-up hold |
| leftIn | input | DATA_W | Left channel sample, two's complement |
| rightIn | input | DATA_W | Right channel sample, two's complement |
| sampleStb | input | 1 | Stages `leftIn` and `rightIn` for the next frame |
| sckIn | input | 1 | Bit clock from the pad, used in slave mode |
| wsIn | input | 1 | Word select from the pad, used in slave mode |
| sckOut | output | 1 | Bit clock toward the pad in master mode |
| sckOe | output | 1 | Output enable for the bit-clock pad |
| wsOut | output | 1 | Word select toward the pad in master mode |
| wsOe | output | 1 | Output enable for the word-select pad |
| sdoOut | output | 1 | Serial data toward the pad |
| sdoOe | output | 1 | Output enable for the data pad |

## Verification
The bench builds the port with 6-bit samples, 8-bit slots, a bit clock of a quarter of the system clock, and hold counts of 2 and 3 frames. With these values a stereo frame takes only 64 clocks, and the wake-up hold ends within a few frames. Every combination of mode, format, extended select and filter flag can therefore be run from standby, through the muted frames, and on to live data. In slave mode the bursts are as long as the slot or as short as one bit past the sample, with idle gaps between them. This shows both that the trailing bits are zero and that the delayed framing fits into the shortest useful burst.

// File: rtl/aser_pkg.sv
package aser_pkg;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic tick;      // bit-clock falling edge: next bit period starts
    logic slotEdge;  // this tick starts a new channel slot
    logic toLeft;    // the slot that starts is the left one
    logic lateMsb;   // MSB is delayed by one bit period
    logic mute;      // force the emitted bit to zero
    logic clear;     // standby: flush the shifter and the data line
  } aserStrobe_t;

endpackage

// File: rtl/aser_ctrl.sv
module aser_ctrl
  import aser_pkg::*;
#(
  parameter int SLOT_BITS  = 32,
  parameter int CLK_DIV    = 4,
  parameter int HOLD_PLAIN = 1024,
  parameter int HOLD_HPF   = 12288
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        slaveSel,
  input  logic        fmtSel,
  input  logic        extSel,
  input  logic        hpfOn,
  input  logic        sckIn,
  input  logic        wsIn,
  output logic        sckOut,
  output logic        wsOut,
  output logic        sckOe,
  output logic        wsOe,
  output logic        sdoOe,
  output aserStrobe_t strb
);

  localparam int DIV_W    = $clog2(CLK_DIV);
  localparam int FR_W     = $clog2(CLK_DIV * SLOT_BITS * 2);
  localparam int HOLD_MAX = (HOLD_HPF > HOLD_PLAIN) ? HOLD_HPF : HOLD_PLAIN;
  localparam int HC_W     = $clog2(HOLD_MAX + 1);
  localparam int SYNC_N   = 3;

  logic              active;
  logic [FR_W-1:0]   frCnt;
  logic [SYNC_N-1:0] sckSync;
  logic [SYNC_N-1:0] wsSync;
  logic              prevWs;
  logic [HC_W-1:0]   holdCnt;
  logic              frameMute;

  logic              masterTick;
  logic              slaveTick;
  logic              tick;
  logic              curWs;
  logic              leftWhenLow;
  logic              isLeft;
  logic              slotEdge;
  logic              frameStart;
  logic [HC_W-1:0]   holdTarget;
  logic              stillHolding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= runEn;
  end

  // Master timing: one counter spans a full stereo frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   frCnt <= '0;
    else if (!active || slaveSel) frCnt <= '0;
    else                         frCnt <= frCnt + 1'b1;
  end

  // Slave inputs: synchronizer chains, one stage per generated flop.
  for (genvar g = 0; g < SYNC_N; g++) begin : gSync
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync[g] <= 1'b1;
          wsSync[g]  <= 1'b0;
        end else begin
          sckSync[g] <= sckIn;
          wsSync[g]  <= wsIn;
        end
      end
    end else begin : gTail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync[g] <= 1'b1;
          wsSync[g]  <= 1'b0;
        end else begin
          sckSync[g] <= sckSync[g-1];
          wsSync[g]  <= wsSync[g-1];
        end
      end
    end
  end

  always_comb begin
    masterTick   = (frCnt[DIV_W-1:0] == '0);
    slaveTick    = sckSync[SYNC_N-1] & ~sckSync[SYNC_N-2];
    tick         = active & (slaveSel ? slaveTick : masterTick);
    curWs        = slaveSel ? wsSync[SYNC_N-2] : frCnt[FR_W-1];
    leftWhenLow  = ~(slaveSel & extSel);
    isLeft       = curWs ^ leftWhenLow;
    slotEdge     = tick & (curWs != prevWs);
    frameStart   = slotEdge & isLeft;
    holdTarget   = hpfOn ? HC_W'(HOLD_HPF) : HC_W'(HOLD_PLAIN);
    stillHolding = (holdCnt < holdTarget);
  end

  // Word-select history; standby parks it on the right-slot level so
  // that the first left slot after wake counts as a frame start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevWs <= 1'b1;
    else if (!active) prevWs <= leftWhenLow;
    else if (tick)   prevWs <= curWs;
  end

  // Wake-up hold: counts frame starts, restarts in standby.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt   <= '0;
      frameMute <= 1'b1;
    end else if (!active) begin
      holdCnt   <= '0;
      frameMute <= 1'b1;
    end else if (frameStart) begin
      frameMute <= stillHolding;
      if (stillHolding) holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    strb.tick     = tick;
    strb.slotEdge = slotEdge;
    strb.toLeft   = isLeft;
    strb.lateMsb  = ~fmtSel;
    strb.mute     = frameStart ? stillHolding : frameMute;
    strb.clear    = ~active;
  end

  assign sckOe  = active & ~slaveSel;
  assign wsOe   = active & ~slaveSel;
  assign sdoOe  = active;
  assign sckOut = sckOe & frCnt[DIV_W-1];
  assign wsOut  = wsOe & frCnt[FR_W-1];

endmodule

// File: rtl/aser_data.sv
module aser_data
  import aser_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              sampleStb,
  input  aserStrobe_t       strb,
  output logic              sdoOut
);

  logic [DATA_W-1:0] stageL;
  logic [DATA_W-1:0] stageR;
  logic [DATA_W-1:0] rightHeld;
  logic [DATA_W-1:0] shReg;
  logic              sdoReg;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] shNext;
  logic              bitOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageL <= '0;
      stageR <= '0;
    end else if (sampleStb) begin
      stageL <= leftIn;
      stageR <= rightIn;
    end
  end

  always_comb begin
    word = strb.slotEdge ? (strb.toLeft ? stageL : rightHeld) : shReg;
    if (strb.slotEdge && strb.lateMsb) begin
      bitOut = 1'b0;
      shNext = word;
    end else begin
      bitOut = word[DATA_W-1];
      shNext = {word[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightHeld <= '0;
      shReg     <= '0;
      sdoReg    <= 1'b0;
    end else if (strb.clear) begin
      shReg  <= '0;
      sdoReg <= 1'b0;
    end else if (strb.tick) begin
      if (strb.slotEdge && strb.toLeft) rightHeld <= stageR;
      shReg  <= shNext;
      sdoReg <= bitOut & ~strb.mute;
    end
  end

  assign sdoOut = sdoReg;

endmodule

// File: rtl/audio_ser_port.sv
module audio_ser_port
  import aser_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int SLOT_BITS  = 32,
  parameter int CLK_DIV    = 4,
  parameter int HOLD_PLAIN = 1024,
  parameter int HOLD_HPF   = 12288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              slaveSel,
  input  logic              fmtSel,
  input  logic              extSel,
  input  logic              hpfOn,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              sampleStb,
  input  logic              sckIn,
  input  logic              wsIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              wsOut,
  output logic              wsOe,
  output logic              sdoOut,
  output logic              sdoOe
);

  aserStrobe_t strb;

  aser_ctrl #(
    .SLOT_BITS (SLOT_BITS),
    .CLK_DIV   (CLK_DIV),
    .HOLD_PLAIN(HOLD_PLAIN),
    .HOLD_HPF  (HOLD_HPF)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .slaveSel(slaveSel),
    .fmtSel  (fmtSel),
    .extSel  (extSel),
    .hpfOn   (hpfOn),
    .sckIn   (sckIn),
    .wsIn    (wsIn),
    .sckOut  (sckOut),
    .wsOut   (wsOut),
    .sckOe   (sckOe),
    .wsOe    (wsOe),
    .sdoOe   (sdoOe),
    .strb    (strb)
  );

  aser_data #(
    .DATA_W(DATA_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .sampleStb(sampleStb),
    .strb     (strb),
    .sdoOut   (sdoOut)
  );

endmodule

// File: rtl/aser_checker.sv
module aser_checker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic slaveSel,
  input logic sckOut,
  input logic sckOe,
  input logic wsOut,
  input logic wsOe,
  input logic sdoOut,
  input logic sdoOe
);

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!sdoOe && !sckOe && !wsOe)) else $error("standby enables"); // R1

  AST_STANDBY_SDO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!sdoOe && $past(!sdoOe)) |-> !sdoOut) else $error("standby data"); // R1

  AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (wsOe && $past(wsOe) && !$stable(wsOut)) |-> $fell(sckOut)) else $error("ws edge"); // R2

  AST_SDO_WHILE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && $past(sckOe) && !$stable(sdoOut)) |-> !sckOut) else $error("sdo edge"); // R3

  AST_SLAVE_PINS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    slaveSel |-> (!sckOe && !wsOe)) else $error("slave pins"); // R6

endmodule

bind audio_ser_port aser_checker uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .slaveSel(slaveSel),
  .sckOut  (sckOut),
  .sckOe   (sckOe),
  .wsOut   (wsOut),
  .wsOe    (wsOe),
  .sdoOut  (sdoOut),
  .sdoOe   (sdoOe)
);

// File: tb/tb_audio_ser_port.sv
`timescale 1ns/1ps
module tb_audio_ser_port;

  localparam int DW   = 6;
  localparam int SB   = 8;
  localparam int CD   = 4;
  localparam int HP   = 2;
  localparam int HH   = 3;
  localparam int HALF = 4;
  localparam int IDLE = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b0;
  logic          slaveSel = 1'b0;
  logic          fmtSel = 1'b1;
  logic          extSel = 1'b0;
  logic          hpfOn = 1'b0;
  logic [DW-1:0] leftIn = '0;
  logic [DW-1:0] rightIn = '0;
  logic          sampleStb = 1'b0;
  logic          sckIn = 1'b1;
  logic          wsIn = 1'b1;
  logic          sckOut, sckOe, wsOut, wsOe, sdoOut, sdoOe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEdge = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_ser_port #(
    .DATA_W(DW), .SLOT_BITS(SB), .CLK_DIV(CD), .HOLD_PLAIN(HP), .HOLD_HPF(HH)
  ) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .slaveSel(slaveSel), .fmtSel(fmtSel),
    .extSel(extSel), .hpfOn(hpfOn), .leftIn(leftIn), .rightIn(rightIn),
    .sampleStb(sampleStb), .sckIn(sckIn), .wsIn(wsIn), .sckOut(sckOut),
    .sckOe(sckOe), .wsOut(wsOut), .wsOe(wsOe), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patL(input int run, input int k);
    return DW'(run * 13 + k * 7 + 9);
  endfunction

  function automatic logic [DW-1:0] patR(input int run, input int k);
    return DW'(~(run * 5 + k * 11 + 3));
  endfunction

  function automatic logic [SB-1:0] expSlot(input logic lj, input logic muted,
                                            input logic [DW-1:0] s);
    if (muted) return '0;
    if (lj) return SB'(s) << (SB - DW);
    return SB'(s) << (SB - DW - 1);
  endfunction

  task automatic stage(input int run, input int k);
    @(negedge clk);
    leftIn = patL(run, k);
    rightIn = patR(run, k);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic standbyCheck();
    @(negedge clk);
    runEn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 standby data enable", sdoOe, 0);
    chk("R1 standby clock enable", sckOe, 0);
    chk("R1 standby ws enable", wsOe, 0);
    chk("R1 standby data low", sdoOut, 0);
  endtask

  task automatic grabSlot(input logic prevWs, output logic wsv, output logic [SB-1:0] bits);
    logic prevSck, prevSdo;
    int firstRise;
    bits = '0;
    firstRise = 0;
    while (wsOut == prevWs) @(negedge clk);
    wsv = wsOut;
    if (lastEdge >= 0) chk("R2 slot length", cyc - lastEdge, SB * CD);
    lastEdge = cyc;
    for (int i = 0; i < SB; i++) begin
      do begin
        prevSck = sckOut;
        prevSdo = sdoOut;
        @(negedge clk);
      end while (!(sckOut && !prevSck));
      bits[SB-1-i] = sdoOut;
      chk("R3 data settled before rise", sdoOut, prevSdo);
      if (i == 0) firstRise = cyc;
      if (i == 1) chk("R2 bit clock period", cyc - firstRise, CD);
    end
  endtask

  task automatic driveSlot(input logic wsv, input int n, output logic [SB-1:0] bits);
    bits = '0;
    @(negedge clk);
    sckIn = 1'b0;
    wsIn = wsv;
    for (int i = 0; i < n; i++) begin
      repeat (HALF) @(negedge clk);
      if (i < SB) bits[SB-1-i] = sdoOut;
      sckIn = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < n - 1) sckIn = 1'b0;
    end
    repeat (IDLE) @(negedge clk);
  endtask

  task automatic masterRun(input int run, input logic fmt, input logic ext, input logic hpf);
    int t;
    logic wsv;
    logic [SB-1:0] bits;
    logic muted;
    t = hpf ? HH : HP;
    standbyCheck();
    slaveSel = 1'b0; fmtSel = fmt; extSel = ext; hpfOn = hpf;
    stage(run, 1);
    @(negedge clk);
    runEn = 1'b1;
    lastEdge = -1;
    stage(run, 2);
    grabSlot(1'b0, wsv, bits);
    chk("R2 right slot ws high", wsv, 1);
    chk("R9 first frame muted", bits, 0);
    for (int k = 2; k <= t + 2; k++) begin
      muted = (k <= t);
      grabSlot(1'b1, wsv, bits);
      chk("R2 left slot ws low", wsv, 0);
      if (muted) chk("R9/R10 hold after wake", bits, 0);
      else if (fmt) chk("R4 left-justified left slot", bits, expSlot(1'b1, 1'b0, patL(run, k)));
      else chk("R5 delayed left slot", bits, expSlot(1'b0, 1'b0, patL(run, k)));
      fork
        stage(run, k + 1);
      join_none
      grabSlot(1'b0, wsv, bits);
      chk("R2 right slot ws", wsv, 1);
      chk("R8 right slot from frame start", bits, expSlot(fmt, muted, patR(run, k)));
    end
  endtask

  task automatic slaveRun(input int run, input logic fmt, input logic ext, input logic hpf);
    int t;
    int n;
    logic leftWs;
    logic [SB-1:0] bits;
    logic [SB-1:0] mask;
    logic muted;
    t = hpf ? HH : HP;
    n = hpf ? SB : DW + 1;
    mask = (n >= SB) ? '1 : ~({SB{1'b1}} >> n);
    leftWs = ext;
    standbyCheck();
    slaveSel = 1'b1; fmtSel = fmt; extSel = ext; hpfOn = hpf;
    sckIn = 1'b1; wsIn = ~leftWs;
    @(negedge clk);
    runEn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 slave clock pin input", sckOe, 0);
    chk("R6 slave ws pin input", wsOe, 0);
    chk("R6 slave data enabled", sdoOe, 1);
    for (int k = 1; k <= t + 2; k++) begin
      muted = (k <= t);
      stage(run, k);
      driveSlot(leftWs, n, bits);
      if (ext) chk("R7 swapped polarity left slot", bits & mask,
                   expSlot(fmt, muted, patL(run, k)) & mask);
      else chk("R6 slave left slot", bits & mask, expSlot(fmt, muted, patL(run, k)) & mask);
      stage(run, k + 1);
      driveSlot(~leftWs, n, bits);
      chk("R8 slave right slot from frame start", bits & mask,
          expSlot(fmt, muted, patR(run, k)) & mask);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data enable", sdoOe, 0);
    chk("R1 reset clock enable", sckOe, 0);
    chk("R1 reset data low", sdoOut, 0);
    rstN = 1'b1;
    for (int cfg = 0; cfg < 8; cfg++)
      masterRun(cfg, cfg[0], cfg[1], cfg[2]);
    for (int cfg = 0; cfg < 8; cfg++)
      slaveRun(cfg + 8, cfg[0], cfg[1], cfg[2]);
    standbyCheck();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule